// File: doc/BRIEF.md
# Flag-Setting Integer Adder/Subtractor

This block is the arithmetic half of an integer datapath. It combines two operands with one of six operations: plain add, add with carry, subtract, subtract with carry, and the two reverse subtractions, which take the second operand minus the first. The result is combinational. Four condition flags (negative, zero, carry, overflow) are held in a register. They are updated on a clock edge when the set-flags strobe is high.

Carry follows the "no borrow" convention. After a subtraction, carry is 1 when no borrow occurred. The carry-in of the with-carry subtractions is the current carry flag, read as an inverted borrow. The flag register can also be loaded straight from a 32-bit status word. This supports context restore and flag-transfer operations.

Top module: `addsub_flags_unit`

## Requirements
- R1: `op_sel` selects the result. Code 0 gives A+B and code 1 gives A+B+C. Code 2 gives A−B and code 3 gives A−B−1+C. Code 4 gives B−A and code 5 gives B−A−1+C. All results are taken modulo 2^WIDTH, and C is the current value of `flag_c`.
- R2: For code 0 with the strobe high, the new carry is 1 exactly when the result is unsigned-less than A. For code 1 with C=1, the new carry is 1 exactly when the result is less than or equal to A. In both cases this is the carry out of the unsigned sum.
- R3: For subtraction of Y from X, the new carry is 1 when X ≥ Y as unsigned values. For codes 3 and 5 with C=0, the new carry is X > Y instead. For codes 2 and 3, X is A and Y is B. For codes 4 and 5, X is B and Y is A.
- R4: For the add codes, the new overflow is 1 when both operands have the same sign and the result sign differs from A. For the subtract codes, the new overflow is 1 when X and Y differ in sign and the result sign differs from X.
- R5: With the strobe high, the new negative flag is the result MSB. The new zero flag is 1 exactly when the result is all zeros.
- R6: Codes 1, 3 and 5 take their carry-in from the registered carry flag, as it stands before the edge.
- R7: With `set_flags` and `psr_wr` both low, the four flags keep their values across the edge. The result still follows the inputs.
- R8: With `psr_wr` high, the flags load from `psr_word` at the edge: N from bit 31, Z from bit 30, C from bit 29 and V from bit 28. This load takes priority over `set_flags`.
- R9: An asynchronous active-low reset clears all four flags.
- R10: The unused codes 6 and 7 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code |
| set_flags | input | 1 | Update flags from this operation at the edge |
| psr_wr | input | 1 | Load flags from the status word at the edge |
| psr_word | input | 32 | Status word (flags in bits 31..28) |
| result | output | WIDTH | Combinational result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The bench builds the unit with its default WIDTH of 32. This lets the reference model work in 64-bit integer arithmetic and check every carry, borrow and signed-overflow boundary exactly. Those boundaries include all-ones plus one, the most negative value minus one, and equal operands under both carry-in values. Chained with-carry operations are covered in the random phase, because earlier flag updates feed the carry-in of later operations.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_ADD = 3'd0;
  localparam logic [OP_W-1:0] OP_ADC = 3'd1;
  localparam logic [OP_W-1:0] OP_SUB = 3'd2;
  localparam logic [OP_W-1:0] OP_SBC = 3'd3;
  localparam logic [OP_W-1:0] OP_RSB = 3'd4;
  localparam logic [OP_W-1:0] OP_RSC = 3'd5;

  localparam int PSR_W   = 32;
  localparam int PSR_N_B = 31;
  localparam int PSR_Z_B = 30;
  localparam int PSR_C_B = 29;
  localparam int PSR_V_B = 28;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/addsub_operand_sel.sv
module addsub_operand_sel
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [OP_W-1:0]  op_sel,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_q,
  output logic [WIDTH-1:0] add_x,
  output logic [WIDTH-1:0] add_y,
  output logic             add_cin
);
  // Subtraction is X + ~Y + cin; reverse forms swap the operands first.
  always_comb begin
    add_x   = op_a;
    add_y   = op_b;
    add_cin = 1'b0;
    unique case (op_sel)
      OP_ADC: add_cin = carry_q;
      OP_SUB: begin add_y = ~op_b; add_cin = 1'b1;    end
      OP_SBC: begin add_y = ~op_b; add_cin = carry_q; end
      OP_RSB: begin add_x = op_b; add_y = ~op_a; add_cin = 1'b1;    end
      OP_RSC: begin add_x = op_b; add_y = ~op_a; add_cin = carry_q; end
      default: ;
    endcase
  end
endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] add_x,
  input  logic [WIDTH-1:0] add_y,
  input  logic             add_cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] full;

  always_comb begin
    full = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_cin};
    sum  = full[MSB:0];
    cout = full[WIDTH];
    ovf  = (add_x[MSB] == add_y[MSB]) && (full[MSB] != add_x[MSB]);
  end
endmodule

// File: rtl/addsub_flag_reg.sv
module addsub_flag_reg
  import addsub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_flags,
  input  logic             psr_wr,
  input  logic [PSR_W-1:0] psr_word,
  input  flags_t           flags_calc,
  output flags_t           flags_q
);
  flags_t flags_d;
  logic   flags_en;

  always_comb begin
    flags_en = psr_wr | set_flags;
    if (psr_wr) begin
      flags_d.n = psr_word[PSR_N_B];
      flags_d.z = psr_word[PSR_Z_B];
      flags_d.c = psr_word[PSR_C_B];
      flags_d.v = psr_word[PSR_V_B];
    end else begin
      flags_d = flags_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  input  logic             set_flags,
  input  logic             psr_wr,
  input  logic [31:0]      psr_word,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  logic [WIDTH-1:0] add_x;
  logic [WIDTH-1:0] add_y;
  logic             add_cin;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic             ovf;
  flags_t           flags_calc;
  flags_t           flags_q;

  addsub_operand_sel #(.WIDTH(WIDTH)) u_sel (
    .op_sel (op_sel),
    .op_a   (op_a),
    .op_b   (op_b),
    .carry_q(flags_q.c),
    .add_x  (add_x),
    .add_y  (add_y),
    .add_cin(add_cin)
  );

  addsub_adder #(.WIDTH(WIDTH)) u_add (
    .add_x  (add_x),
    .add_y  (add_y),
    .add_cin(add_cin),
    .sum    (sum),
    .cout   (cout),
    .ovf    (ovf)
  );

  always_comb begin
    flags_calc.n = sum[WIDTH-1];
    flags_calc.z = (sum == '0);
    flags_calc.c = cout;
    flags_calc.v = ovf;
  end

  addsub_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_flags (set_flags),
    .psr_wr    (psr_wr),
    .psr_word  (psr_word),
    .flags_calc(flags_calc),
    .flags_q   (flags_q)
  );

  assign result = sum;
  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;
endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [2:0]       op_sel,
  input logic             set_flags,
  input logic             psr_wr,
  input logic [31:0]      psr_word,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_v
);
  logic arith_upd;
  assign arith_upd = set_flags && !psr_wr;

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_flags && !psr_wr) |=> ($stable(flag_n) && $stable(flag_z) && $stable(flag_c) && $stable(flag_v)));

  p_psr_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    psr_wr |=> ({flag_n, flag_z, flag_c, flag_v} == $past(psr_word[31:28])));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arith_upd |=> (flag_z == ($past(result) == '0)));

  p_neg_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arith_upd |=> (flag_n == $past(result[WIDTH-1])));

  p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_upd && op_sel == 3'd0) |=> (flag_c == ($past(result) < $past(op_a))));

  p_sub_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_upd && op_sel == 3'd2) |=> (flag_c == ($past(op_a) >= $past(op_b))));

  p_sub_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_upd && op_sel == 3'd2) |=>
      (flag_v == (($past(op_a[WIDTH-1]) != $past(op_b[WIDTH-1])) &&
                  ($past(result[WIDTH-1]) != $past(op_a[WIDTH-1])))));
endmodule

bind addsub_flags_unit addsub_flags_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_a     (op_a),
  .op_b     (op_b),
  .op_sel   (op_sel),
  .set_flags(set_flags),
  .psr_wr   (psr_wr),
  .psr_word (psr_word),
  .result   (result),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .flag_c   (flag_c),
  .flag_v   (flag_v)
);

// File: tb/addsub_flags_unit_tb.sv
`timescale 1ns/1ps
module addsub_flags_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] op_a, op_b;
  logic [2:0]   op_sel;
  logic         set_flags, psr_wr;
  logic [31:0]  psr_word;
  logic [W-1:0] result;
  logic         flag_n, flag_z, flag_c, flag_v;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  // reference flag state: {n,z,c,v}
  logic [3:0] m_fl;

  always #2.5 clk = ~clk;

  addsub_flags_unit #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .set_flags(set_flags), .psr_wr(psr_wr), .psr_word(psr_word),
    .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural model: 64-bit integer arithmetic.
  function automatic void model(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic cin, output logic [W-1:0] res, output logic [3:0] fl);
    longint ua = longint'(a), ub = longint'(b);
    longint sa = longint'($signed(a)), sb = longint'($signed(b));
    longint u, s;
    logic   c;
    case (op)
      3'd1:    begin u = ua + ub + cin;        s = sa + sb + cin;        c = (u >> W) != 0; end
      3'd2:    begin u = ua - ub;              s = sa - sb;              c = (u >= 0);      end
      3'd3:    begin u = ua - ub - 1 + cin;    s = sa - sb - 1 + cin;    c = (u >= 0);      end
      3'd4:    begin u = ub - ua;              s = sb - sa;              c = (u >= 0);      end
      3'd5:    begin u = ub - ua - 1 + cin;    s = sb - sa - 1 + cin;    c = (u >= 0);      end
      default: begin u = ua + ub;              s = sa + sb;              c = (u >> W) != 0; end
    endcase
    res = u[W-1:0];
    fl  = {res[W-1], res == '0, c, (s > 64'sh7FFFFFFF) || (s < -64'sh80000000)};
  endfunction

  task automatic step(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic sf, input logic pw, input logic [31:0] pword, input string tag);
    logic [W-1:0] er;
    logic [3:0]   ef;
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b; set_flags = sf; psr_wr = pw; psr_word = pword;
    #1;
    model(op, a, b, m_fl[1], er, ef);
    chk({tag, " result"}, longint'(result), longint'(er));
    if (pw)      m_fl = pword[31:28];
    else if (sf) m_fl = ef;
    @(posedge clk); #1;
    chk({tag, " flags"}, longint'({flag_n, flag_z, flag_c, flag_v}), longint'(m_fl));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_a = '0; op_b = '0; op_sel = '0;
    set_flags = 1'b0; psr_wr = 1'b0; psr_word = '0; m_fl = '0;
    repeat (3) @(posedge clk);
    #1 chk("R9 reset flags", longint'({flag_n, flag_z, flag_c, flag_v}), 0);
    @(negedge clk) rst_n = 1'b1;

    step(3'd0, 32'hFFFF_FFFF, 32'h1,         1, 0, 0, "R2 R5 add wrap");
    step(3'd0, 32'h7FFF_FFFF, 32'h1,         1, 0, 0, "R4 add ovf");
    step(3'd0, 32'h8000_0000, 32'h8000_0000, 1, 0, 0, "R4 add neg ovf");
    step(3'd1, 32'h5,         32'hFFFF_FFFF, 1, 0, 0, "R2 R6 adc c1 equal");
    step(3'd2, 32'h5,         32'h5,         1, 0, 0, "R3 sub equal");
    step(3'd2, 32'h3,         32'h5,         1, 0, 0, "R3 sub borrow");
    step(3'd3, 32'h5,         32'h5,         1, 0, 0, "R3 R6 sbc c0");
    step(3'd2, 32'h8000_0000, 32'h1,         1, 0, 0, "R4 sub ovf");
    step(3'd3, 32'h5,         32'h5,         1, 0, 0, "R3 R6 sbc c1");
    step(3'd4, 32'h3,         32'hA,         1, 0, 0, "R1 R3 rsb");
    step(3'd5, 32'hA,         32'h3,         1, 0, 0, "R1 R3 rsc");
    step(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, "R7 hold");
    step(3'd2, 32'h0,         32'h1,         0, 0, 0, "R7 hold sub");
    step(3'd0, 32'h0,         32'h0,         1, 1, 32'hA000_0000, "R8 load priority");
    step(3'd1, 32'h1,         32'h1,         0, 1, 32'h5000_0000, "R8 load");
    step(3'd6, 32'hFFFF_FFFF, 32'h2,         1, 0, 0, "R10 code6");
    step(3'd7, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0, 0, "R10 code7");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] rop = 3'($urandom_range(0, 7));
      logic [W-1:0] ra = $urandom, rb = $urandom;
      if (i % 5 == 0) rb = ra;
      step(rop, ra, rb, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 15) == 0),
           $urandom, "R1 random");
    end

    step(3'd0, 0, 0, 0, 1, 32'hF000_0000, "R8 set all");
    @(negedge clk) rst_n = 1'b0; m_fl = '0;
    #1 chk("R9 async reset", longint'({flag_n, flag_z, flag_c, flag_v}), 0);
    @(negedge clk) rst_n = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule